// File: doc/BRIEF.md
# Trap and Interrupt Entry Sequencer

This block moves a small 16-bit processor into a privileged handler and back again. Three causes can start an entry: an illegal-instruction fault, a supervisor-call trap, and an external device interrupt. All three run the same multi-cycle sequence and differ only in the vector they read. The sequence first holds the current program counter and status word. It then fetches a new PC and status word from the event's vector. Last, it pushes the held pair onto the stack of the mode that the new status word selects. A return request runs the reverse sequence: it pops the PC and then the status word from the active stack.

The block owns the architectural PC, the status word (PSW) and one stack pointer for each of the four mode values. The core's normal register writes reach these through a small load port. Every memory access goes through a word-wide request/acknowledge port. The core raises `boundary` between instructions and stalls while `busy` is high. The PSW uses bits 15:14 for the current mode and bits 13:12 for the previous mode. Bit 7 enables interrupts. Mode value 0 is the privileged mode.

Top module: `trap_seq`

## Requirements
- R1: After reset, `pc` = 0x0200, `psw` = 0, all four stack pointers are 0, `busy` = 0 and `mem_req` = 0. No interrupt is pending.
- R2: An illegal fault uses vector 0x0010, a trap uses vector 0x0020 and an interrupt uses vector 0x0030. The new PC is read from the vector address and the new PSW from vector+2.
- R3: On entry, the held PSW is written to SP-2 and the held PC to SP-4. SP is the stack pointer of the mode in bits 15:14 of the fetched PSW. That stack pointer ends 4 lower, and the other three are unchanged.
- R4: After entry, PSW bits 15:14 and 11:0 come from the fetched PSW. Bits 13:12 hold the pre-entry current mode.
- R5: A return reads the PC from SP and the PSW from SP+2, using the stack pointer of the current mode. It restores both unchanged and adds 4 to that stack pointer.
- R6: When several requests meet at one boundary, the priority is illegal, then trap, then enabled pending interrupt, then return. A losing illegal, trap or return request is dropped.
- R7: `pc`, `psw` and the stack pointers keep their values until the last memory acknowledge of a sequence, and then all change on the same edge. `busy` is high from the cycle after the start until that edge.
- R8: A sequence starts only in a cycle with `boundary` = 1 and `busy` = 0. Illegal, trap and return requests at any other time are ignored.
- R9: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`. An entry does read vector, read vector+2, write SP-2, write SP-4, in that order. A return does read SP, then read SP+2.
- R10: `irq` high in any cycle sets a pending flag. The flag is taken at a later boundary only while PSW bit 7 is 1, stays set while bit 7 is 0, and clears when its entry starts.
- R11: `ld_en` writes `ld_val` to the target that `ld_sel` picks: 0 = PC, 1 = PSW, 4 to 7 = the stack pointer of mode `ld_sel[1:0]`. The write is ignored while `busy` is high and in the cycle a sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Core is between instructions |
| ill_req | input | 1 | Illegal-instruction fault request |
| trap_req | input | 1 | Supervisor-call trap request |
| ret_req | input | 1 | Return-from-handler request |
| irq | input | 1 | External interrupt request |
| ld_en | input | 1 | Register write from the core |
| ld_sel | input | 3 | Register write target |
| ld_val | input | 16 | Register write value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with ack |
| mem_ack | input | 1 | Access complete |
| busy | output | 1 | Sequence in progress, core stalls |
| pc | output | 16 | Program counter |
| psw | output | 16 | Status word |
| sp_flat | output | 64 | Stack pointers, mode 0 in bits 15:0 |

## Verification
The bench targets simultaneous requests at one boundary. A wrong priority would fetch the wrong vector and leave a different PC. It holds an interrupt while PSW bit 7 is clear and then enables it. A design that drops or ignores the pending flag would either never enter or enter too early. It checks the previous-mode field and the choice of bank. Mixing up the old and new mode, or pushing onto the pre-entry stack, changes the PSW or the wrong stack pointer. It also drives requests off the boundary and register writes in mid-sequence. A design that accepts either one leaves PC, PSW or a stack pointer different from the model. Random memory latency exposes a sequence that commits early or moves on before the acknowledge.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_ILL,
        K_TRAP,
        K_IRQ,
        K_RET
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_VEC_PC,
        S_VEC_PSW,
        S_PUSH_PSW,
        S_PUSH_PC,
        S_POP_PC,
        S_POP_PSW
    } seq_e;

endpackage

// File: rtl/trap_seq_arb.sv
module trap_seq_arb
    import trap_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  boundary,
    input  logic  busy,
    input  logic  ill_req,
    input  logic  trap_req,
    input  logic  ret_req,
    input  logic  irq,
    input  logic  irq_en,
    output logic  start,
    output kind_e kind
);

    typedef struct packed {
        logic pend;
    } arb_t;

    arb_t arb_d, arb_q;

    always_comb begin
        arb_d = arb_q;
        kind  = K_NONE;
        if (boundary && !busy) begin
            if (ill_req)                   kind = K_ILL;
            else if (trap_req)             kind = K_TRAP;
            else if (arb_q.pend && irq_en) kind = K_IRQ;
            else if (ret_req)              kind = K_RET;
        end
        start = (kind != K_NONE);
        arb_d.pend = (arb_q.pend && (kind != K_IRQ)) || irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    // R10: a masked request survives until it is enabled
    p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_q.pend && !irq_en) |=> arb_q.pend);

endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
    import trap_seq_pkg::*;
#(
    parameter int             W        = 16,
    parameter logic [W-1:0]   VEC_ILL  = 16'h0010,
    parameter logic [W-1:0]   VEC_TRAP = 16'h0020,
    parameter logic [W-1:0]   VEC_IRQ  = 16'h0030
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  kind_e                kind,
    input  logic [W-1:0]         pc,
    input  logic [W-1:0]         psw,
    input  logic [4*W-1:0]       sp_flat,
    input  logic                 mem_ack,
    input  logic [W-1:0]         mem_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [W-1:0]         mem_addr,
    output logic [W-1:0]         mem_wdata,
    output logic                 busy,
    output logic                 commit_en,
    output logic [W-1:0]         commit_pc,
    output logic [W-1:0]         commit_psw,
    output logic [1:0]           commit_mode,
    output logic [W-1:0]         commit_sp
);

    localparam int MW = 2;
    localparam int CUR_LO = W - MW;
    localparam int PRV_LO = W - 2 * MW;
    localparam logic [W-1:0] TWO  = W'(2);
    localparam logic [W-1:0] FOUR = W'(4);

    typedef struct packed {
        seq_e          st;
        logic [W-1:0]  hold_pc;
        logic [W-1:0]  hold_psw;
        logic [W-1:0]  new_pc;
        logic [W-1:0]  new_psw;
        logic [W-1:0]  base;
        logic [W-1:0]  vec;
        logic [MW-1:0] smode;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    function automatic logic [W-1:0] sp_of(input logic [4*W-1:0] flat, input logic [MW-1:0] m);
        return flat[int'(m)*W +: W];
    endfunction

    always_comb begin
        fsm_d       = fsm_q;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        commit_en   = 1'b0;
        commit_pc   = fsm_q.new_pc;
        commit_psw  = fsm_q.new_psw;
        commit_mode = fsm_q.smode;
        commit_sp   = fsm_q.base;
        case (fsm_q.st)
            S_IDLE: begin
                if (start) begin
                    fsm_d.hold_pc  = pc;
                    fsm_d.hold_psw = psw;
                    fsm_d.smode    = psw[W-1:CUR_LO];
                    fsm_d.base     = sp_of(sp_flat, psw[W-1:CUR_LO]);
                    case (kind)
                        K_ILL:   fsm_d.vec = VEC_ILL;
                        K_TRAP:  fsm_d.vec = VEC_TRAP;
                        default: fsm_d.vec = VEC_IRQ;
                    endcase
                    fsm_d.st = (kind == K_RET) ? S_POP_PC : S_VEC_PC;
                end
            end
            S_VEC_PC: begin
                mem_req  = 1'b1;
                mem_addr = fsm_q.vec;
                if (mem_ack) begin
                    fsm_d.new_pc = mem_rdata;
                    fsm_d.st     = S_VEC_PSW;
                end
            end
            S_VEC_PSW: begin
                mem_req  = 1'b1;
                mem_addr = fsm_q.vec + TWO;
                if (mem_ack) begin
                    fsm_d.new_psw = {mem_rdata[W-1:CUR_LO], fsm_q.hold_psw[W-1:CUR_LO],
                                     mem_rdata[PRV_LO-1:0]};
                    fsm_d.smode   = mem_rdata[W-1:CUR_LO];
                    fsm_d.base    = sp_of(sp_flat, mem_rdata[W-1:CUR_LO]);
                    fsm_d.st      = S_PUSH_PSW;
                end
            end
            S_PUSH_PSW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = fsm_q.base - TWO;
                mem_wdata = fsm_q.hold_psw;
                if (mem_ack) fsm_d.st = S_PUSH_PC;
            end
            S_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = fsm_q.base - FOUR;
                mem_wdata = fsm_q.hold_pc;
                if (mem_ack) begin
                    commit_en = 1'b1;
                    commit_sp = fsm_q.base - FOUR;
                    fsm_d.st  = S_IDLE;
                end
            end
            S_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = fsm_q.base;
                if (mem_ack) begin
                    fsm_d.new_pc = mem_rdata;
                    fsm_d.st     = S_POP_PSW;
                end
            end
            S_POP_PSW: begin
                mem_req  = 1'b1;
                mem_addr = fsm_q.base + TWO;
                if (mem_ack) begin
                    commit_en  = 1'b1;
                    commit_psw = mem_rdata;
                    commit_sp  = fsm_q.base + FOUR;
                    fsm_d.st   = S_IDLE;
                end
            end
            default: fsm_d.st = S_IDLE;
        endcase
        busy = (fsm_q.st != S_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= '0;
        else        fsm_q <= fsm_d;
    end

    // R9: no memory traffic outside a sequence
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_seq_pkg::*;
#(
    parameter int           W        = 16,
    parameter int           IE_BIT   = 7,
    parameter logic [W-1:0] RST_PC   = 16'h0200,
    parameter logic [W-1:0] VEC_ILL  = 16'h0010,
    parameter logic [W-1:0] VEC_TRAP = 16'h0020,
    parameter logic [W-1:0] VEC_IRQ  = 16'h0030
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             ill_req,
    input  logic             trap_req,
    input  logic             ret_req,
    input  logic             irq,
    input  logic             ld_en,
    input  logic [2:0]       ld_sel,
    input  logic [W-1:0]     ld_val,
    output logic             mem_req,
    output logic             mem_we,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_wdata,
    input  logic [W-1:0]     mem_rdata,
    input  logic             mem_ack,
    output logic             busy,
    output logic [W-1:0]     pc,
    output logic [W-1:0]     psw,
    output logic [4*W-1:0]   sp_flat
);

    localparam int NMODE = 4;

    typedef struct packed {
        logic [W-1:0]             pc;
        logic [W-1:0]             psw;
        logic [NMODE-1:0][W-1:0]  sp;
    } arch_t;

    arch_t        arch_d, arch_q;
    logic         start_w;
    kind_e        kind_w;
    logic         commit_en;
    logic [W-1:0] commit_pc, commit_psw, commit_sp;
    logic [1:0]   commit_mode;

    trap_seq_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .busy     (busy),
        .ill_req  (ill_req),
        .trap_req (trap_req),
        .ret_req  (ret_req),
        .irq      (irq),
        .irq_en   (arch_q.psw[IE_BIT]),
        .start    (start_w),
        .kind     (kind_w)
    );

    trap_seq_fsm #(
        .W        (W),
        .VEC_ILL  (VEC_ILL),
        .VEC_TRAP (VEC_TRAP),
        .VEC_IRQ  (VEC_IRQ)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_w),
        .kind        (kind_w),
        .pc          (arch_q.pc),
        .psw         (arch_q.psw),
        .sp_flat     (arch_q.sp),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .busy        (busy),
        .commit_en   (commit_en),
        .commit_pc   (commit_pc),
        .commit_psw  (commit_psw),
        .commit_mode (commit_mode),
        .commit_sp   (commit_sp)
    );

    always_comb begin
        arch_d = arch_q;
        if (commit_en) begin
            arch_d.pc              = commit_pc;
            arch_d.psw             = commit_psw;
            arch_d.sp[commit_mode] = commit_sp;
        end else if (ld_en && !busy && !start_w) begin
            if (ld_sel[2])            arch_d.sp[ld_sel[1:0]] = ld_val;
            else if (ld_sel == 3'd0)  arch_d.pc  = ld_val;
            else if (ld_sel == 3'd1)  arch_d.psw = ld_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arch_q     <= '0;
            arch_q.pc  <= RST_PC;
        end else begin
            arch_q <= arch_d;
        end
    end

    assign pc      = arch_q.pc;
    assign psw     = arch_q.psw;
    assign sp_flat = arch_q.sp;

    // R7: architectural state frozen until the commit edge
    p_atomic_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit_en) |=> ($stable(pc) && $stable(psw) && $stable(sp_flat)));

    // R9: request held steady until acknowledged
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R8: nothing starts off an instruction boundary
    p_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !busy) |=> !busy);

endmodule

// File: tb/trap_seq_bench.sv
`timescale 1ns/1ps
module trap_seq_bench;

    localparam int W = 16;
    localparam logic [W-1:0] V_ILL  = 16'h0010;
    localparam logic [W-1:0] V_TRAP = 16'h0020;
    localparam logic [W-1:0] V_IRQ  = 16'h0030;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boundary = 0, ill_req = 0, trap_req = 0, ret_req = 0, irq = 0, ld_en = 0;
    logic [2:0]   ld_sel = '0;
    logic [W-1:0] ld_val = '0;
    logic         mem_req, mem_we, busy;
    logic [W-1:0] mem_addr, mem_wdata, pc, psw;
    logic [W-1:0] mem_rdata = '0;
    logic         mem_ack = 1'b0;
    logic [4*W-1:0] sp_flat;

    always #2 clk = ~clk;

    trap_seq u_trap_seq (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .ill_req(ill_req),
        .trap_req(trap_req), .ret_req(ret_req), .irq(irq), .ld_en(ld_en),
        .ld_sel(ld_sel), .ld_val(ld_val), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .busy(busy), .pc(pc), .psw(psw), .sp_flat(sp_flat)
    );

    logic [W-1:0] mem [0:255];
    logic [W-1:0] log_a [0:7];
    logic         log_w [0:7];
    int           log_n = 0;
    int           wait_n = 0;

    logic [W-1:0] m_pc, m_psw;
    logic [W-1:0] m_sp [0:3];
    bit           m_pend;
    int           n_chk = 0, n_fail = 0, cyc = 0;

    function automatic logic [W-1:0] rd(input logic [W-1:0] a);
        return mem[a[8:1]];
    endfunction

    // memory responder, random latency 0..2 cycles
    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (mem_req) begin
            if (wait_n == 0) begin
                if (mem_we) mem[mem_addr[8:1]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[8:1]];
                if (log_n < 8) begin
                    log_a[log_n] = mem_addr;
                    log_w[log_n] = mem_we;
                    log_n++;
                end
                mem_ack = 1'b1;
                wait_n  = $urandom_range(0, 2);
            end else begin
                wait_n--;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_arch(input string tag);
        chk({tag, " pc"}, pc, m_pc);
        chk({tag, " psw"}, psw, m_psw);
        for (int m = 0; m < 4; m++) chk({tag, " sp"}, sp_flat[m*W +: W], m_sp[m]);
    endtask

    task automatic load(input logic [2:0] sel, input logic [W-1:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_val = v;
        @(negedge clk);
        ld_en = 1'b0;
        if (sel[2])          m_sp[sel[1:0]] = v;
        else if (sel == 3'd0) m_pc = v;
        else if (sel == 3'd1) m_psw = v;
        chk("R11 load", (sel == 3'd0) ? pc : (sel == 3'd1) ? psw : sp_flat[int'(sel[1:0])*W +: W], v);
    endtask

    task automatic irq_pulse();
        @(negedge clk); irq = 1'b1;
        @(negedge clk); irq = 1'b0;
        m_pend = 1'b1;
    endtask

    task automatic fire(input bit bnd, input bit ill, input bit trp, input bit ret,
                        input bit ldb, input string tag);
        int k, n, mode_i, cnt;
        logic [W-1:0] vec, npc, npsw, base, opc, opsw;
        logic [W-1:0] ea [0:3];
        bit ew [0:3];
        bit stable_ok;
        k = 0; n = 0; mode_i = 0; vec = '0; npc = '0; npsw = '0; base = '0;
        if (bnd) begin
            if (ill)                       k = 1;
            else if (trp)                  k = 2;
            else if (m_pend && m_psw[7])   k = 3;
            else if (ret)                  k = 4;
        end
        opc = m_pc; opsw = m_psw;
        if (k >= 1 && k <= 3) begin
            vec    = (k == 1) ? V_ILL : (k == 2) ? V_TRAP : V_IRQ;
            npc    = rd(vec);
            npsw   = rd(vec + 16'd2);
            mode_i = int'(npsw[15:14]);
            base   = m_sp[mode_i];
            ea[0] = vec;  ea[1] = vec + 16'd2; ea[2] = base - 16'd2; ea[3] = base - 16'd4;
            ew[0] = 0; ew[1] = 0; ew[2] = 1; ew[3] = 1;
            n = 4;
        end else if (k == 4) begin
            mode_i = int'(opsw[15:14]);
            base   = m_sp[mode_i];
            npc    = rd(base);
            npsw   = rd(base + 16'd2);
            ea[0] = base; ea[1] = base + 16'd2; ea[2] = '0; ea[3] = '0;
            ew[0] = 0; ew[1] = 0; ew[2] = 0; ew[3] = 0;
            n = 2;
        end
        log_n = 0;
        @(negedge clk);
        boundary = bnd; ill_req = ill; trap_req = trp; ret_req = ret;
        @(negedge clk);
        boundary = 0; ill_req = 0; trap_req = 0; ret_req = 0;
        chk({tag, " R7 R8 busy after request"}, {15'b0, busy}, {15'b0, (k != 0)});
        stable_ok = 1'b1;
        cnt = 0;
        while (busy && cnt < 64) begin
            if (ldb && cnt == 0) begin
                ld_en = 1'b1; ld_sel = 3'd0; ld_val = 16'hDEAD;
            end else begin
                ld_en = 1'b0;
            end
            if (pc !== opc || psw !== opsw) stable_ok = 1'b0;
            @(negedge clk);
            cnt++;
        end
        ld_en = 1'b0;
        chk({tag, " R7 sequence ends"}, {15'b0, busy}, 16'd0);
        chk({tag, " R7 no early update"}, {15'b0, stable_ok}, 16'd1);
        if (k >= 1 && k <= 3) begin
            m_pc  = npc;
            m_psw = {npsw[15:14], opsw[15:14], npsw[11:0]};
            m_sp[mode_i] = base - 16'd4;
            if (k == 3) m_pend = 1'b0;
            chk({tag, " R3 pushed psw"}, rd(base - 16'd2), opsw);
            chk({tag, " R3 pushed pc"}, rd(base - 16'd4), opc);
        end else if (k == 4) begin
            m_pc  = npc;
            m_psw = npsw;
            m_sp[mode_i] = base + 16'd4;
        end
        check_arch({tag, " R2 R4 R5 R6"});
        chk({tag, " R9 access count"}, 16'(log_n), 16'(n));
        for (int i = 0; i < n; i++) begin
            chk({tag, " R9 access addr"}, log_a[i], ea[i]);
            chk({tag, " R9 access dir"}, {15'b0, log_w[i]}, {15'b0, ew[i]});
        end
    endtask

    task automatic set_vec(input logic [W-1:0] v, input logic [W-1:0] p, input logic [W-1:0] s);
        mem[v[8:1]]            = p;
        mem[(v + 16'd2) >> 1]  = s;
    endtask

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 5);
        m_pc = 16'h0200; m_psw = '0; m_pend = 1'b0;
        for (int m = 0; m < 4; m++) m_sp[m] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_arch("R1 reset");
        chk("R1 busy", {15'b0, busy}, 16'd0);
        chk("R1 mem_req", {15'b0, mem_req}, 16'd0);

        // R11 loads
        load(3'd4, 16'h01F0);
        load(3'd5, 16'h0160);
        load(3'd6, 16'h0130);
        load(3'd7, 16'h0180);
        load(3'd0, 16'h0400);
        load(3'd1, 16'hC000);

        set_vec(V_ILL,  16'h1000, 16'h0005);
        set_vec(V_TRAP, 16'h2000, 16'h0080);
        set_vec(V_IRQ,  16'h3000, 16'h4000);

        // R2 R3 R4: trap from user mode, then R5 return
        fire(1, 0, 1, 0, 0, "trap");
        fire(1, 0, 0, 1, 0, "return");
        // R6 priority: illegal beats trap and return
        fire(1, 1, 1, 1, 0, "R6 ill wins");
        fire(1, 0, 0, 1, 0, "return after ill");
        // R6: trap beats return
        fire(1, 0, 1, 1, 0, "R6 trap wins");
        fire(1, 0, 0, 1, 0, "return after trap");
        // R8: requests off the boundary are ignored
        fire(0, 1, 1, 1, 0, "R8 off boundary");
        // R10: masked interrupt is held
        irq_pulse();
        fire(1, 0, 0, 0, 0, "R10 masked");
        load(3'd1, 16'hC080);
        fire(1, 0, 0, 0, 0, "R10 enabled irq");
        fire(1, 0, 0, 1, 0, "return from irq");
        // R6: trap outranks an enabled pending interrupt; irq then nests
        irq_pulse();
        fire(1, 0, 1, 0, 0, "R6 trap over irq");
        fire(1, 0, 0, 1, 0, "R6 R10 irq over return");
        // R11: load during a sequence is ignored
        fire(1, 0, 1, 0, 1, "R11 load while busy");

        for (int it = 0; it < 300; it++) begin
            set_vec(V_ILL,  16'($urandom) & 16'hFFFE, 16'($urandom));
            set_vec(V_TRAP, 16'($urandom) & 16'hFFFE, 16'($urandom));
            set_vec(V_IRQ,  16'($urandom) & 16'hFFFE, 16'($urandom));
            for (int m = 0; m < 4; m++)
                if (m_sp[m] < 16'h0080 || m_sp[m] > 16'h01F0)
                    load(3'(4 + m), 16'h0100 + (16'($urandom_range(0, 112)) << 1));
            if ($urandom_range(0, 3) == 0) irq_pulse();
            if ($urandom_range(0, 5) == 0) load(3'd1, 16'($urandom));
            fire($urandom_range(0, 7) != 0, $urandom_range(0, 5) == 0,
                 $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
                 $urandom_range(0, 9) == 0, "random");
        end
        summary();
    end

endmodule